// File: doc/BRIEF.md
# Branch-Folding Instruction Queue

This block sits between instruction fetch and dispatch. It holds up to eight fetched 32-bit instructions in age order, each with its address. It deletes branches whose outcome can be settled on the spot, so they never use a dispatch slot. Each cycle fetch may write up to eight instructions in one group. Dispatch may take up to three of the oldest entries.

A scanner classifies the four oldest entries. The first branch it meets is folded when its outcome is already known. That holds for an unconditional branch, and for a conditional branch whose condition bit has no pending writer. In the same cycle the queue raises a redirect carrying the resolved next address. The branch and every younger entry are dropped at the clock edge, so the instruction fetched from the redirect address takes the branch's place. Branches that cannot be settled stay in the queue and leave through dispatch like any other instruction, bound for the branch unit.

Bit numbering in this document is little-endian: bit 31 is the most significant bit of an instruction word.

Top module: `bf_iqueue`

## Requirements
- R1: After a synchronous active-high reset the queue is empty. No dispatch slot is valid, no redirect is raised, and `fetch_ready` is high even for a request of eight instructions.
- R2: A fetch group of `fetch_count` instructions (0 to 8) is written when `fetch_valid` and `fetch_ready` are both high. Element k of the group comes from bits [32k+31:32k] of `fetch_instr` and `fetch_addr`, and element 0 is the oldest.
- R3: Dispatch slot d shows the d-th oldest entry, up to three slots, and the valid slots form a contiguous run starting at slot 0. Driving `disp_take` with n removes the n oldest entries and keeps the order of the rest.
- R4: An instruction whose bits [31:26] equal 18 is an unconditional branch. If it has bit 0 (link) clear and is the first branch among the four oldest entries, it is folded. `redirect_valid` rises in the same cycle, and `redirect_addr` is the sign-extended bits [25:2] shifted left by 2, added to the branch address, or taken alone when bit 1 is set. At the clock edge the branch and all younger entries are removed, and older entries are kept.
- R5: An instruction whose bits [31:26] equal 16 is a conditional branch. It tests condition bit number bits [20:16] of `cr_value`. It is folded like R4 when bits 0 and 1... are as follows: bit 0 is clear, bit 23 is set (no counter use), and either bit 25 is set (condition ignored) or `cr_pending` for that bit is clear. It is taken when bit 25 is set or the condition bit equals bit 24. The taken target is the sign-extended bits [15:2] shifted left by 2, added to the address or used alone when bit 1 is set. When not taken, the redirect goes to the branch address plus 4.
- R6: A conditional branch whose condition bit is pending, and whose bit 25 is clear, is not folded. It stays in the queue and is offered on dispatch as an ordinary entry.
- R7: A branch with bit 0 set, or a conditional branch with bit 23 clear, is never folded.
- R8: Only the four oldest entries are scanned. A foldable branch in position 4 or later causes no redirect until it moves into the window.
- R9: Only the first branch in the window is considered. A branch that cannot be folded blocks folding of any younger branch behind it.
- R10: While a fold is in progress, dispatch offers only entries older than the folded branch, and `fetch_ready` is low.
- R11: `fetch_ready` is low when the free entries are fewer than `fetch_count`. A group offered while `fetch_ready` is low is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch offers a group |
| fetch_count | input | 4 | Number of instructions in the group (0 to 8) |
| fetch_instr | input | 256 | Instruction words, element k at bits [32k+31:32k] |
| fetch_addr | input | 256 | Instruction addresses, same packing |
| fetch_ready | output | 1 | Queue can take the offered group this cycle |
| cr_value | input | 32 | Current condition bits |
| cr_pending | input | 32 | Condition bits with a write still outstanding |
| redirect_valid | output | 1 | A branch is being folded this cycle |
| redirect_addr | output | 32 | Next fetch address for the folded branch |
| disp_valid | output | 3 | Valid flags of dispatch slots, slot 0 oldest |
| disp_instr | output | 96 | Instruction words of dispatch slots |
| disp_addr | output | 96 | Addresses of dispatch slots |
| disp_take | input | 2 | Number of entries dispatch removes this cycle |

## Verification
A wrong occupancy count appears in the same cycle as a wrong `disp_valid` run or a wrong `fetch_ready` decision. Loss or reordering of entries appears on `disp_instr` and `disp_addr` once the bad entry reaches the three oldest slots. A wrong scan choice or wrong target appears on `redirect_valid` and `redirect_addr` in the very cycle the branch enters the four-entry window. A wrong truncation appears one cycle later as extra or missing dispatch slots. The directed cases therefore sample these ports right after each edge that loads, pops or folds.

// File: rtl/bfq_pkg.sv
`timescale 1ns/1ps
package bfq_pkg;

    localparam int unsigned IW = 32;
    localparam int unsigned AW = 32;

    localparam logic [5:0] OP_JUMP = 6'd18;
    localparam logic [5:0] OP_CJUMP = 6'd16;

    typedef enum logic [1:0] {
        BK_NONE   = 2'd0,
        BK_UNCOND = 2'd1,
        BK_COND   = 2'd2
    } brkind_e;

    typedef struct packed {
        logic [IW-1:0] instr;
        logic [AW-1:0] addr;
    } qent_t;

    typedef struct packed {
        brkind_e       kind;
        logic          can_fold;
        logic [AW-1:0] target;
    } scan_t;

    function automatic logic [AW-1:0] pick_target(input logic [AW-1:0] pc,
                                                  input logic [AW-1:0] offset,
                                                  input logic absolute);
        return absolute ? offset : pc + offset;
    endfunction

endpackage

// File: rtl/bfq_classify.sv
`timescale 1ns/1ps
module bfq_classify
    import bfq_pkg::*;
#(
    parameter int CRW = 32
) (
    input  logic           valid,
    input  qent_t          ent,
    input  logic [CRW-1:0] cr_value,
    input  logic [CRW-1:0] cr_pending,
    output scan_t          res
);
    localparam int BIW = $clog2(CRW);

    logic [5:0]     opc;
    logic           link, absolute;
    logic           ign_cond, want_val, no_ctr;
    logic [BIW-1:0] bit_sel;
    logic           known, taken;
    logic [AW-1:0]  off_long, off_short;

    assign opc       = ent.instr[31:26];
    assign link      = ent.instr[0];
    assign absolute  = ent.instr[1];
    assign ign_cond  = ent.instr[25];
    assign want_val  = ent.instr[24];
    assign no_ctr    = ent.instr[23];
    assign bit_sel   = ent.instr[16 +: BIW];
    assign off_long  = {{(AW-26){ent.instr[25]}}, ent.instr[25:2], 2'b00};
    assign off_short = {{(AW-16){ent.instr[15]}}, ent.instr[15:2], 2'b00};
    assign known     = ign_cond || !cr_pending[bit_sel];
    assign taken     = ign_cond || (cr_value[bit_sel] == want_val);

    always_comb begin
        res = '0;
        res.kind = BK_NONE;
        if (valid && opc == OP_JUMP) begin
            res.kind     = BK_UNCOND;
            res.can_fold = !link;
            res.target   = pick_target(ent.addr, off_long, absolute);
        end else if (valid && opc == OP_CJUMP) begin
            res.kind     = BK_COND;
            res.can_fold = !link && no_ctr && known;
            res.target   = taken ? pick_target(ent.addr, off_short, absolute)
                                 : ent.addr + AW'(4);
        end
    end

endmodule

// File: rtl/bfq_fold_pick.sv
`timescale 1ns/1ps
module bfq_fold_pick
    import bfq_pkg::*;
#(
    parameter int SCAN = 4
) (
    input  scan_t                     scans [SCAN],
    output logic                      hit,
    output logic [$clog2(SCAN)-1:0]   idx,
    output logic [AW-1:0]             target
);
    localparam int SIW = $clog2(SCAN);

    logic seen;

    always_comb begin
        seen   = 1'b0;
        hit    = 1'b0;
        idx    = '0;
        target = '0;
        for (int i = 0; i < SCAN; i++) begin
            if (!seen && scans[i].kind != BK_NONE) begin
                seen   = 1'b1;
                hit    = scans[i].can_fold;
                idx    = SIW'(i);
                target = scans[i].target;
            end
        end
    end

endmodule

// File: rtl/bfq_store.sv
`timescale 1ns/1ps
module bfq_store
    import bfq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int FW    = 8,
    parameter int DW    = 3,
    parameter int VIS   = 4,
    localparam int CNTW = $clog2(DEPTH+1),
    localparam int FCW  = $clog2(FW+1),
    localparam int PCW  = $clog2(DW+1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [FCW-1:0]  push_n,
    input  qent_t           push_ent [FW],
    input  logic [PCW-1:0]  pop_n,
    input  logic            trunc,
    input  logic [CNTW-1:0] trunc_at,
    output qent_t           ent_o [VIS],
    output logic [CNTW-1:0] count
);
    localparam int SIW = $clog2(DEPTH);
    localparam int FIW = $clog2(FW);

    qent_t           ent_q [DEPTH];
    qent_t           nxt   [DEPTH];
    logic [CNTW-1:0] kept, base, nxt_cnt;

    always_comb begin
        kept    = trunc ? trunc_at : count;
        base    = kept - CNTW'(pop_n);
        nxt_cnt = base + CNTW'(push_n);
        for (int i = 0; i < DEPTH; i++) begin
            nxt[i] = '0;
            if (i < int'(base)) begin
                if (i + int'(pop_n) < DEPTH)
                    nxt[i] = ent_q[SIW'(i + int'(pop_n))];
            end else if (i - int'(base) < int'(push_n)) begin
                if (i - int'(base) < FW)
                    nxt[i] = push_ent[FIW'(i - int'(base))];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            count <= nxt_cnt;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= nxt[i];
        end
    end

    for (genvar v = 0; v < VIS; v++) begin : g_vis
        assign ent_o[v] = ent_q[v];
    end

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    // R4
    trunc_keep_chk: assert property (@(posedge clk) disable iff (rst)
        trunc |=> count <= $past(trunc_at));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push_n == '0 && pop_n == '0 && !trunc) |=> ($stable(count) && $stable(ent_q[0])));

endmodule

// File: rtl/bf_iqueue.sv
`timescale 1ns/1ps
module bf_iqueue
    import bfq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int FW    = 8,
    parameter int DW    = 3,
    parameter int SCAN  = 4,
    parameter int CRW   = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      fetch_valid,
    input  logic [$clog2(FW+1)-1:0]   fetch_count,
    input  logic [FW*IW-1:0]          fetch_instr,
    input  logic [FW*AW-1:0]          fetch_addr,
    output logic                      fetch_ready,
    input  logic [CRW-1:0]            cr_value,
    input  logic [CRW-1:0]            cr_pending,
    output logic                      redirect_valid,
    output logic [AW-1:0]             redirect_addr,
    output logic [DW-1:0]             disp_valid,
    output logic [DW*IW-1:0]          disp_instr,
    output logic [DW*AW-1:0]          disp_addr,
    input  logic [$clog2(DW+1)-1:0]   disp_take
);
    localparam int CNTW = $clog2(DEPTH+1);
    localparam int FCW  = $clog2(FW+1);
    localparam int PCW  = $clog2(DW+1);
    localparam int VIS  = (SCAN > DW) ? SCAN : DW;

    qent_t                push_ent [FW];
    qent_t                ents     [VIS];
    scan_t                scans    [SCAN];
    logic [CNTW-1:0]      q_count;
    logic                 fold_hit;
    logic [$clog2(SCAN)-1:0] fold_idx;
    logic [AW-1:0]        fold_tgt;
    logic [CNTW-1:0]      lim, avail_n;
    logic [PCW-1:0]       pop_n;
    logic [FCW-1:0]       push_n;

    for (genvar f = 0; f < FW; f++) begin : g_unpack
        assign push_ent[f].instr = fetch_instr[f*IW +: IW];
        assign push_ent[f].addr  = fetch_addr[f*AW +: AW];
    end

    for (genvar s = 0; s < SCAN; s++) begin : g_scan
        bfq_classify #(.CRW(CRW)) u_cls (
            .valid      (q_count > CNTW'(s)),
            .ent        (ents[s]),
            .cr_value   (cr_value),
            .cr_pending (cr_pending),
            .res        (scans[s])
        );
    end

    bfq_fold_pick #(.SCAN(SCAN)) u_pick (
        .scans  (scans),
        .hit    (fold_hit),
        .idx    (fold_idx),
        .target (fold_tgt)
    );

    assign lim     = fold_hit ? CNTW'(fold_idx) : q_count;
    assign avail_n = (lim > CNTW'(DW)) ? CNTW'(DW) : lim;
    assign pop_n   = (CNTW'(disp_take) > avail_n) ? PCW'(avail_n) : disp_take;

    assign fetch_ready = !fold_hit && ((DEPTH - int'(q_count)) >= int'(fetch_count));
    assign push_n      = (fetch_valid && fetch_ready) ? fetch_count : '0;

    assign redirect_valid = fold_hit;
    assign redirect_addr  = fold_tgt;

    for (genvar d = 0; d < DW; d++) begin : g_disp
        assign disp_valid[d]         = lim > CNTW'(d);
        assign disp_instr[d*IW +: IW] = ents[d].instr;
        assign disp_addr[d*AW +: AW]  = ents[d].addr;
    end

    bfq_store #(.DEPTH(DEPTH), .FW(FW), .DW(DW), .VIS(VIS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push_n   (push_n),
        .push_ent (push_ent),
        .pop_n    (pop_n),
        .trunc    (fold_hit),
        .trunc_at (CNTW'(fold_idx)),
        .ent_o    (ents),
        .count    (q_count)
    );

    // R3
    disp_run_chk: assert property (@(posedge clk) disable iff (rst)
        ((disp_valid + 1'b1) & disp_valid) == '0);

    // R10
    fold_older_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> ($countones(disp_valid) <= int'(fold_idx)));

    // R4
    fold_trim_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> int'(q_count) < SCAN);

    // R2
    push_land_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && fetch_ready) |=> int'(q_count) >= int'($past(fetch_count)));

endmodule

// File: tb/tb_bf_iqueue.sv
`timescale 1ns/1ps
module tb_bf_iqueue;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fetch_valid;
    logic [3:0]   fetch_count;
    logic [255:0] fetch_instr;
    logic [255:0] fetch_addr;
    logic         fetch_ready;
    logic [31:0]  cr_value;
    logic [31:0]  cr_pending;
    logic         redirect_valid;
    logic [31:0]  redirect_addr;
    logic [2:0]   disp_valid;
    logic [95:0]  disp_instr;
    logic [95:0]  disp_addr;
    logic [1:0]   disp_take;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] fi [8];
    logic [31:0] fa [8];

    always #2.5 clk = ~clk;

    bf_iqueue dut (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_count(fetch_count),
        .fetch_instr(fetch_instr), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready),
        .cr_value(cr_value), .cr_pending(cr_pending),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .disp_valid(disp_valid), .disp_instr(disp_instr), .disp_addr(disp_addr),
        .disp_take(disp_take)
    );

    function automatic logic [31:0] mk_alu(input int n);
        return {6'd31, 26'(n)};
    endfunction

    function automatic logic [31:0] mk_b(input logic [23:0] li, input logic aa, input logic lk);
        return {6'd18, li, aa, lk};
    endfunction

    function automatic logic [31:0] mk_bc(input logic [4:0] bo, input logic [4:0] bi,
                                          input logic [13:0] bd, input logic aa, input logic lk);
        return {6'd16, bo, bi, bd, aa, lk};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fetch_valid = 1'b0; fetch_count = '0; fetch_instr = '0; fetch_addr = '0;
        cr_value = '0; cr_pending = '0; disp_take = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic load(input int n);
        for (int k = 0; k < 8; k++) begin
            fetch_instr[k*32 +: 32] = fi[k];
            fetch_addr[k*32 +: 32]  = fa[k];
        end
        fetch_valid = 1'b1;
        fetch_count = 4'(n);
        @(posedge clk);
        #1 fetch_valid = 1'b0;
        fetch_count = '0;
        #1;
    endtask

    task automatic take(input int n);
        disp_take = 2'(n);
        @(posedge clk);
        #1 disp_take = '0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        fetch_count = 4'd8;
        #1;
        chk("R1 disp_valid", 32'(disp_valid), 0);
        chk("R1 redirect", 32'(redirect_valid), 0);
        chk("R1 ready for 8", 32'(fetch_ready), 1);
        fetch_count = '0;
    endtask

    task automatic t_fifo();
        do_reset();
        for (int k = 0; k < 5; k++) begin fi[k] = mk_alu(k + 1); fa[k] = 32'h100 + 32'(4*k); end
        load(5);
        chk("R2 R3 valid after load", 32'(disp_valid), 3'b111);
        chk("R3 slot0 instr", disp_instr[31:0], mk_alu(1));
        chk("R3 slot2 instr", disp_instr[95:64], mk_alu(3));
        chk("R3 slot1 addr", disp_addr[63:32], 32'h104);
        take(2);
        chk("R3 slot0 after take", disp_instr[31:0], mk_alu(3));
        chk("R3 slot2 after take", disp_instr[95:64], mk_alu(5));
        take(3);
        chk("R3 empty after drain", 32'(disp_valid), 0);
    endtask

    task automatic t_backpress();
        do_reset();
        for (int k = 0; k < 6; k++) begin fi[k] = mk_alu(k + 1); fa[k] = 32'h200 + 32'(4*k); end
        load(6);
        for (int k = 0; k < 3; k++) begin
            fi[k] = mk_alu(100 + k); fa[k] = 32'h300 + 32'(4*k);
            fetch_instr[k*32 +: 32] = fi[k];
            fetch_addr[k*32 +: 32]  = fa[k];
        end
        fetch_valid = 1'b1;
        fetch_count = 4'd3;
        #1 chk("R11 ready low for 3 of 2 free", 32'(fetch_ready), 0);
        @(posedge clk);
        #1 fetch_count = 4'd2;
        #1 chk("R2 ready for 2 of 2 free", 32'(fetch_ready), 1);
        @(posedge clk);
        #1 fetch_valid = 1'b0;
        fetch_count = 4'd1;
        #1 chk("R11 ready low when full", 32'(fetch_ready), 0);
        fetch_count = '0;
        take(3);
        chk("R3 order after partial drain", disp_instr[31:0], mk_alu(4));
        take(3);
        chk("R11 refused group not written", 32'(disp_valid), 3'b011);
        chk("R2 first accepted element", disp_instr[31:0], mk_alu(100));
        chk("R2 second accepted element", disp_addr[63:32], 32'h304);
        take(2);
        chk("R3 empty", 32'(disp_valid), 0);
    endtask

    task automatic t_uncond();
        do_reset();
        fi[0] = mk_alu(1); fi[1] = mk_alu(2); fi[2] = mk_b(24'h000010, 1'b0, 1'b0);
        fi[3] = mk_alu(3); fi[4] = mk_alu(4);
        for (int k = 0; k < 5; k++) fa[k] = 32'h1000 + 32'(4*k);
        load(5);
        chk("R4 redirect raised", 32'(redirect_valid), 1);
        chk("R4 relative target", redirect_addr, 32'h1048);
        chk("R10 only older entries offered", 32'(disp_valid), 3'b011);
        fetch_count = 4'd1;
        #1 chk("R10 fetch held during fold", 32'(fetch_ready), 0);
        fetch_count = '0;
        take(1);
        chk("R4 redirect drops", 32'(redirect_valid), 0);
        chk("R4 younger flushed", 32'(disp_valid), 3'b001);
        chk("R4 older kept", disp_instr[31:0], mk_alu(2));
        take(1);
        chk("R4 empty", 32'(disp_valid), 0);

        fi[0] = mk_b(24'h000800, 1'b1, 1'b0); fa[0] = 32'h3000;
        fi[1] = mk_alu(9);                    fa[1] = 32'h3004;
        load(2);
        chk("R4 absolute target", redirect_addr, 32'h2000);
        chk("R10 no slot when branch oldest", 32'(disp_valid), 0);
        @(posedge clk); #1;
        chk("R4 branch and follower removed", 32'(disp_valid), 0);

        fi[0] = mk_b(24'hFFFFF0, 1'b0, 1'b0); fa[0] = 32'h4000;
        load(1);
        chk("R4 backward target", redirect_addr, 32'h3FC0);
        @(posedge clk); #1;
    endtask

    task automatic t_cond();
        do_reset();
        fi[0] = mk_bc(5'b01100, 5'd5, 14'h0020, 1'b0, 1'b0); fa[0] = 32'h500;
        fi[1] = mk_alu(1);                                   fa[1] = 32'h504;
        load(2);
        chk("R5 known cond folds", 32'(redirect_valid), 1);
        chk("R5 not taken falls through", redirect_addr, 32'h504);
        cr_value[5] = 1'b1;
        #1 chk("R5 taken target", redirect_addr, 32'h580);
        @(posedge clk); #1;
        cr_value = '0;
        cr_pending[9] = 1'b1;
        fi[0] = mk_bc(5'b10100, 5'd9, 14'h3FFC, 1'b0, 1'b0); fa[0] = 32'h600;
        load(1);
        chk("R5 ignore-cond folds though pending", 32'(redirect_valid), 1);
        chk("R5 ignore-cond target", redirect_addr, 32'h5F0);
        @(posedge clk); #1;
        cr_pending = '0;
    endtask

    task automatic t_pending();
        do_reset();
        cr_pending[7] = 1'b1;
        fi[0] = mk_bc(5'b01100, 5'd7, 14'h0008, 1'b0, 1'b0); fa[0] = 32'h700;
        fi[1] = mk_alu(1);                                   fa[1] = 32'h704;
        load(2);
        chk("R6 pending cond not folded", 32'(redirect_valid), 0);
        chk("R6 branch offered on dispatch", disp_instr[31:0], fi[0]);
        take(1);
        chk("R6 follower next", disp_addr[31:0], 32'h704);
        take(1);
        cr_pending = '0;
    endtask

    task automatic t_nofold();
        do_reset();
        fi[0] = mk_b(24'h000010, 1'b0, 1'b1); fa[0] = 32'h7A0;
        load(1);
        chk("R7 linking branch kept", 32'(redirect_valid), 0);
        take(1);
        fi[0] = mk_bc(5'b01000, 5'd3, 14'h0008, 1'b0, 1'b0); fa[0] = 32'h7B0;
        load(1);
        chk("R7 counter branch kept", 32'(redirect_valid), 0);
        chk("R7 counter branch dispatched", 32'(disp_valid), 3'b001);
        take(1);
    endtask

    task automatic t_window();
        do_reset();
        for (int k = 0; k < 6; k++) begin fi[k] = mk_alu(k + 1); fa[k] = 32'h800 + 32'(4*k); end
        fi[4] = mk_b(24'h000004, 1'b0, 1'b0);
        load(6);
        chk("R8 branch at position 4 ignored", 32'(redirect_valid), 0);
        take(1);
        chk("R8 branch enters window", 32'(redirect_valid), 1);
        chk("R8 target", redirect_addr, 32'h820);
        chk("R10 three older offered", 32'(disp_valid), 3'b111);
        take(3);
    endtask

    task automatic t_block();
        do_reset();
        cr_pending[2] = 1'b1;
        fi[0] = mk_bc(5'b01100, 5'd2, 14'h0010, 1'b0, 1'b0); fa[0] = 32'h900;
        fi[1] = mk_b(24'h000008, 1'b0, 1'b0);                fa[1] = 32'h904;
        load(2);
        chk("R9 younger branch blocked", 32'(redirect_valid), 0);
        take(1);
        chk("R9 folds once oldest", 32'(redirect_valid), 1);
        chk("R9 target", redirect_addr, 32'h924);
        @(posedge clk); #1;
        cr_pending = '0;
    endtask

    initial begin
        t_reset();
        t_fifo();
        t_backpress();
        t_uncond();
        t_cond();
        t_pending();
        t_nofold();
        t_window();
        t_block();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule